// File: doc/BRIEF.md
# Instrument status reporting register model

This block keeps the status registers of a programmable instrument and turns them into a service request. It has three 16-bit register groups: operation, measurement and questionable. Each group has a live condition image, a latched event register and an enable mask. An event bit is captured when its condition bit goes from 0 to 1. The group's summary is any event bit that is also enabled. A separate 8-bit standard event register captures one-cycle pulses from the command and execution logic and has its own enable mask.

The summaries and two queue-present flags from outside are gathered into an 8-bit status byte. A service-request enable mask selects which status byte bits may raise the master summary. A small state machine turns the master summary into a latched request-for-service flag, and that flag drives `srq_out`. Software reaches every register through one register-access port that takes a 4-bit select and returns read data one cycle after the read strobe.

The service-request machine has three states. `SRQ_QUIET` means there is no request. `SRQ_ASSERTED` means a request is latched. `SRQ_HELD` means the request was polled while the master summary was still high. The transitions are:
- QUIET→ASSERTED when the master summary is high.
- ASSERTED→QUIET on a serial poll with the summary low.
- ASSERTED→HELD on a serial poll with the summary high.
- HELD→QUIET when the summary falls.

Top module: `instr_status_core`

Register selects: 0/1/2 are operation condition/event/enable, 3/4/5 are measurement, 6/7/8 are questionable, 9 is standard event, 10 is standard enable, 11 is the status byte query, 12 is the serial poll, 13 is the service-request enable, 14 is clear-events (write only) and 15 is unused.

## Requirements
- R1: After power-on reset, every select reads 0, provided the condition and queue-flag inputs are low, and `srq_out` is 0.
- R2: Writes to read-only selects (0, 1, 3, 4, 6, 7, 9, 11, 12, 15) change nothing: not the condition images, not the events and not the request flag. Only the reset input and select 14 clear status contents.
- R3: A group event bit sets on a 0-to-1 change of its condition bit and stays set while the condition holds or falls. Reading the event select returns the latched value and clears it. A new edge in the same cycle as that read leaves the bit set.
- R4: A write to a group enable select stores `wr_data` with bit 15 dropped and reads back unchanged. Writing 0 clears the whole mask and removes the group's summary.
- R5: A group summary is the OR of (event AND enable). It appears in status byte bit 7 for operation, bit 0 for measurement and bit 3 for questionable.
- R6: Standard event bits 0 and 2..7 latch when their input pulse is high. Bit 1 always reads 0, in both the event and the enable register. The event register clears on read. Its summary (event AND enable, ORed) is status byte bit 5.
- R7: Status byte bit 4 follows `msg_avail` and bit 2 follows `err_avail`. Bit 1 is 0.
- R8: Bit 15 of every group condition, event and enable register reads 0.
- R9: The master summary is the OR of (status byte AND service-request enable) over every bit except 6. The enable stores bit 6 as 0. A status byte query (select 11) shows the live master summary in bit 6.
- R10: The request-for-service flag sets when the master summary is high from `SRQ_QUIET`. A serial poll (select 12) returns the flag in bit 6 and clears it. The flag does not set again until the master summary has fallen. `srq_out` shows the flag.
- R11: A write to select 14 clears all four event registers and leaves enables and condition images unchanged.
- R12: `rd_data` updates one cycle after `rd_en` with the value selected in that cycle. It holds when `rd_en` is low. Select 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| oper_cond_in | input | 16 | Live operation condition bits |
| meas_cond_in | input | 16 | Live measurement condition bits |
| ques_cond_in | input | 16 | Live questionable condition bits (bit 8 = calibration summary) |
| std_evt_in | input | 8 | Standard event pulses |
| msg_avail | input | 1 | Output queue not empty |
| err_avail | input | 1 | Error queue not empty |
| reg_sel | input | 4 | Register select |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, one cycle after `rd_en` |
| srq_out | output | 1 | Request-for-service flag |

## Verification
The bench sweeps every bit of every group. It checks that falling edges and held levels never re-arm an event, and that a new edge landing on the same cycle as an event read survives the clear. A design that gave priority to the clear would lose that edge. The bench sweeps all 256 service-request enable values against a known status byte. A design that let bit 6 feed its own summary would report a request that never clears. The poll-while-still-high sequence catches a flag that re-fires without a fall, and the write-to-read-only sequence catches stores or clears decoded from the wrong strobe.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int GRP_W  = 16;
    localparam int BYTE_W = 8;

    // status byte bit positions (decoded by the request logic)
    localparam int SB_MEAS = 0;
    localparam int SB_ERR  = 2;
    localparam int SB_QUES = 3;
    localparam int SB_MSG  = 4;
    localparam int SB_STD  = 5;
    localparam int SB_RQS  = 6;
    localparam int SB_OPER = 7;

    typedef enum logic [3:0] {
        SEL_OPER_COND = 4'd0,
        SEL_OPER_EVT  = 4'd1,
        SEL_OPER_EN   = 4'd2,
        SEL_MEAS_COND = 4'd3,
        SEL_MEAS_EVT  = 4'd4,
        SEL_MEAS_EN   = 4'd5,
        SEL_QUES_COND = 4'd6,
        SEL_QUES_EVT  = 4'd7,
        SEL_QUES_EN   = 4'd8,
        SEL_STD_EVT   = 4'd9,
        SEL_STD_EN    = 4'd10,
        SEL_SB_QUERY  = 4'd11,
        SEL_SB_POLL   = 4'd12,
        SEL_SRE       = 4'd13,
        SEL_CLEAR     = 4'd14,
        SEL_NONE      = 4'd15
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRQ_QUIET    = 2'd0,
        SRQ_ASSERTED = 2'd1,
        SRQ_HELD     = 2'd2
    } srq_state_e;
endpackage

// File: rtl/isr_edge_detect.sv
module isr_edge_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] level_q,
    output logic [W-1:0] rise
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= src;
    end

    assign rise = src & ~level_q;
endmodule

// File: rtl/isr_event_group.sv
module isr_event_group #(
    parameter int           W         = 16,
    parameter logic [W-1:0] LIVE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         evt_rd,
    input  logic         evt_clr_all,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] en_q,
    output logic         summary
);
    logic [W-1:0] kept;

    // a read or a global clear drops old bits; new sets always survive
    assign kept = (evt_rd || evt_clr_all) ? '0 : evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= kept | (set_vec & LIVE_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata & LIVE_MASK;
    end

    assign summary = |(evt_q & en_q);
endmodule

// File: rtl/isr_service_req.sv
module isr_service_req
    import isr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] sb_base,
    input  logic          sre_wr,
    input  logic [BW-1:0] sre_wdata,
    input  logic          poll_rd,
    output logic [BW-1:0] sre_q,
    output logic          mss,
    output logic          rqs
);
    localparam logic [BW-1:0] RQS_BIT = BW'(1) << SB_RQS;

    srq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sre_q <= '0;
        else if (sre_wr) sre_q <= sre_wdata & ~RQS_BIT;
    end

    assign mss = |(sb_base & sre_q & ~RQS_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRQ_QUIET:    if (mss) state_d = SRQ_ASSERTED;
            SRQ_ASSERTED: if (poll_rd) state_d = mss ? SRQ_HELD : SRQ_QUIET;
            SRQ_HELD:     if (!mss) state_d = SRQ_QUIET;
            default:      state_d = SRQ_QUIET;
        endcase
    end

    always_comb begin
        rqs = (state_q == SRQ_ASSERTED);
    end
endmodule

// File: rtl/isr_regport.sv
module isr_regport
    import isr_pkg::*;
#(
    parameter int NGRP = 3,
    parameter int W    = 16,
    parameter int BW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [3:0]               sel,
    input  logic [NGRP-1:0][W-1:0]   grp_cond,
    input  logic [NGRP-1:0][W-1:0]   grp_evt,
    input  logic [NGRP-1:0][W-1:0]   grp_en,
    input  logic [BW-1:0]            std_evt,
    input  logic [BW-1:0]            std_en,
    input  logic [BW-1:0]            sre,
    input  logic [BW-1:0]            sb_base,
    input  logic                     mss,
    input  logic                     rqs,
    output logic [W-1:0]             rd_data
);
    logic [W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        case (reg_sel_e'(sel))
            SEL_OPER_COND: rd_next = grp_cond[0];
            SEL_OPER_EVT:  rd_next = grp_evt[0];
            SEL_OPER_EN:   rd_next = grp_en[0];
            SEL_MEAS_COND: rd_next = grp_cond[1];
            SEL_MEAS_EVT:  rd_next = grp_evt[1];
            SEL_MEAS_EN:   rd_next = grp_en[1];
            SEL_QUES_COND: rd_next = grp_cond[2];
            SEL_QUES_EVT:  rd_next = grp_evt[2];
            SEL_QUES_EN:   rd_next = grp_en[2];
            SEL_STD_EVT:   rd_next = W'(std_evt);
            SEL_STD_EN:    rd_next = W'(std_en);
            SEL_SB_QUERY:  rd_next = W'(sb_base | (BW'(mss) << SB_RQS));
            SEL_SB_POLL:   rd_next = W'(sb_base | (BW'(rqs) << SB_RQS));
            SEL_SRE:       rd_next = W'(sre);
            default:       rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/instr_status_core.sv
module instr_status_core
    import isr_pkg::*;
#(
    parameter int              G_W       = GRP_W,
    parameter int              B_W       = BYTE_W,
    parameter logic [BYTE_W-1:0] STD_LIVE = 8'hFD
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [G_W-1:0] oper_cond_in,
    input  logic [G_W-1:0] meas_cond_in,
    input  logic [G_W-1:0] ques_cond_in,
    input  logic [B_W-1:0] std_evt_in,
    input  logic           msg_avail,
    input  logic           err_avail,
    input  logic [3:0]     reg_sel,
    input  logic [G_W-1:0] wr_data,
    input  logic           wr_en,
    input  logic           rd_en,
    output logic [G_W-1:0] rd_data,
    output logic           srq_out
);
    localparam int             NGRP     = 3;
    localparam logic [G_W-1:0] GRP_LIVE = {1'b0, {(G_W-1){1'b1}}};

    logic [NGRP-1:0][G_W-1:0] grp_src, grp_cond, grp_rise, grp_evt, grp_en;
    logic [NGRP-1:0]          grp_sum;
    logic [B_W-1:0]           std_evt, std_en, sre_q, sb_base;
    logic                     std_sum, mss, rqs, clr_all, poll_rd, std_rd, std_en_wr, sre_wr;

    assign grp_src[0] = oper_cond_in & GRP_LIVE;
    assign grp_src[1] = meas_cond_in & GRP_LIVE;
    assign grp_src[2] = ques_cond_in & GRP_LIVE;

    assign clr_all   = wr_en && (reg_sel == SEL_CLEAR);
    assign poll_rd   = rd_en && (reg_sel == SEL_SB_POLL);
    assign std_rd    = rd_en && (reg_sel == SEL_STD_EVT);
    assign std_en_wr = wr_en && (reg_sel == SEL_STD_EN);
    assign sre_wr    = wr_en && (reg_sel == SEL_SRE);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [3:0] EVT_SEL = 4'(int'(SEL_OPER_EVT) + 3 * g);
        localparam logic [3:0] EN_SEL  = 4'(int'(SEL_OPER_EN) + 3 * g);

        isr_edge_detect #(.W(G_W)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (grp_src[g]),
            .level_q (grp_cond[g]),
            .rise    (grp_rise[g])
        );

        isr_event_group #(.W(G_W), .LIVE_MASK(GRP_LIVE)) u_grp (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_vec     (grp_rise[g]),
            .evt_rd      (rd_en && (reg_sel == EVT_SEL)),
            .evt_clr_all (clr_all),
            .en_wr       (wr_en && (reg_sel == EN_SEL)),
            .en_wdata    (wr_data),
            .evt_q       (grp_evt[g]),
            .en_q        (grp_en[g]),
            .summary     (grp_sum[g])
        );
    end

    isr_event_group #(.W(B_W), .LIVE_MASK(STD_LIVE)) u_std (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_vec     (std_evt_in),
        .evt_rd      (std_rd),
        .evt_clr_all (clr_all),
        .en_wr       (std_en_wr),
        .en_wdata    (wr_data[B_W-1:0]),
        .evt_q       (std_evt),
        .en_q        (std_en),
        .summary     (std_sum)
    );

    always_comb begin
        sb_base          = '0;
        sb_base[SB_MEAS] = grp_sum[1];
        sb_base[SB_ERR]  = err_avail;
        sb_base[SB_QUES] = grp_sum[2];
        sb_base[SB_MSG]  = msg_avail;
        sb_base[SB_STD]  = std_sum;
        sb_base[SB_OPER] = grp_sum[0];
    end

    isr_service_req #(.BW(B_W)) u_srq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sb_base   (sb_base),
        .sre_wr    (sre_wr),
        .sre_wdata (wr_data[B_W-1:0]),
        .poll_rd   (poll_rd),
        .sre_q     (sre_q),
        .mss       (mss),
        .rqs       (rqs)
    );

    isr_regport #(.NGRP(NGRP), .W(G_W), .BW(B_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (reg_sel),
        .grp_cond (grp_cond),
        .grp_evt  (grp_evt),
        .grp_en   (grp_en),
        .std_evt  (std_evt),
        .std_en   (std_en),
        .sre      (sre_q),
        .sb_base  (sb_base),
        .mss      (mss),
        .rqs      (rqs),
        .rd_data  (rd_data)
    );

    assign srq_out = rqs;
endmodule

// File: rtl/isr_checker.sv
module isr_checker
    import isr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_sel,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        rd_en,
    input logic [15:0] rd_data,
    input logic        srq,
    input logic        mss,
    input logic [2:0]  grp_sum
);
    a_r12_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r8_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15] == 1'b0);

    a_r10_flag_needs_summary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srq) |-> $past(mss));

    a_r10_summary_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mss) && !(rd_en && reg_sel == SEL_SB_POLL)) |=> srq);

    a_r10_poll_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && rd_en && reg_sel == SEL_SB_POLL && !mss) |=> !srq);

    a_r4_zero_mask_oper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_OPER_EN && wr_data == 16'h0) |=> !grp_sum[0]);

    a_r4_zero_mask_meas: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_MEAS_EN && wr_data == 16'h0) |=> !grp_sum[1]);

    a_r4_zero_mask_ques: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_QUES_EN && wr_data == 16'h0) |=> !grp_sum[2]);
endmodule

bind instr_status_core isr_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .srq     (srq_out),
    .mss     (mss),
    .grp_sum (grp_sum)
);

// File: tb/sim_instr_status_core.sv
module sim_instr_status_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] oper_cond = '0, meas_cond = '0, ques_cond = '0;
    logic [7:0]  std_evt = '0;
    logic        msg_avail = 1'b0, err_avail = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        srq_out;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    instr_status_core u0 (
        .clk(clk), .rst_n(rst_n),
        .oper_cond_in(oper_cond), .meas_cond_in(meas_cond), .ques_cond_in(ques_cond),
        .std_evt_in(std_evt), .msg_avail(msg_avail), .err_avail(err_avail),
        .reg_sel(reg_sel), .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en),
        .rd_data(rd_data), .srq_out(srq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [15:0] d);
        @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [15:0] v);
        @(negedge clk); reg_sel = s; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
    endtask

    task automatic set_cond(input int g, input logic [15:0] v);
        case (g)
            0:       oper_cond = v;
            1:       meas_cond = v;
            default: ques_cond = v;
        endcase
    endtask

    function automatic int sb_pos(input int g);
        return (g == 0) ? 7 : ((g == 1) ? 0 : 3);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after power-on
        chk("R1 srq after reset", {15'b0, srq_out}, 16'h0);
        for (int s = 0; s < 16; s++) begin
            rd(4'(s), v);
            chk("R1 reset read", v, 16'h0);
        end

        // R3, R8: rising-edge latch sweep on each bit of each group
        for (int g = 0; g < 3; g++) begin
            for (int i = 0; i < 16; i++) begin
                logic [15:0] bitv;
                bitv = 16'h1 << i;
                set_cond(g, bitv);
                @(negedge clk);
                rd(4'(3 * g), v);     chk("R8 condition image", v, bitv & 16'h7FFF);
                rd(4'(3 * g + 1), v); chk("R3 event latched", v, bitv & 16'h7FFF);
                rd(4'(3 * g + 1), v); chk("R3 read clears, level holds", v, 16'h0);
                set_cond(g, 16'h0);
                @(negedge clk);
            end
            rd(4'(3 * g + 1), v); chk("R3 falling edge ignored", v, 16'h0);
        end

        // R3: set in the same cycle as the clearing read survives
        set_cond(0, 16'h0001);
        @(negedge clk);
        @(negedge clk); reg_sel = 4'd1; rd_en = 1'b1; oper_cond = 16'h0003;
        @(negedge clk); rd_en = 1'b0;
        chk("R3 read returns old event", rd_data, 16'h0001);
        rd(4'd1, v); chk("R3 same-cycle set kept", v, 16'h0002);
        rd(4'd1, v); chk("R3 cleared afterwards", v, 16'h0);
        oper_cond = 16'h0;

        // R4, R8: enable store, top bit dropped, zero clears
        for (int g = 0; g < 3; g++) begin
            for (int i = 0; i < 16; i++) begin
                wr(4'(3 * g + 2), 16'h1 << i);
                rd(4'(3 * g + 2), v);
                chk("R4 enable readback", v, (16'h1 << i) & 16'h7FFF);
            end
            wr(4'(3 * g + 2), 16'hFFFF); rd(4'(3 * g + 2), v); chk("R8 enable top bit", v, 16'h7FFF);
            wr(4'(3 * g + 2), 16'h0);    rd(4'(3 * g + 2), v); chk("R4 zero clears mask", v, 16'h0);
        end

        // R5: summary into the status byte under an enable sweep
        for (int g = 0; g < 3; g++) begin
            set_cond(g, 16'h8AF0);
            @(negedge clk);
            set_cond(g, 16'h0);
            for (int k = 0; k < 16; k++) begin
                logic [15:0] expv;
                wr(4'(3 * g + 2), 16'h1 << k);
                expv = (((16'h0AF0 >> k) & 16'h1) != 0) ? (16'h1 << sb_pos(g)) : 16'h0;
                rd(4'd11, v);
                chk("R5 group summary bit", v, expv);
            end
            wr(4'(3 * g + 2), 16'h0);
            rd(4'd11, v); chk("R4 zero mask drops summary", v, 16'h0);
        end

        // R11: clear-events write
        for (int g = 0; g < 3; g++) wr(4'(3 * g + 2), 16'h7FFF);
        rd(4'd11, v); chk("R5 all summaries", v, 16'h0089);
        wr(4'd14, 16'hFFFF);
        for (int g = 0; g < 3; g++) begin
            rd(4'(3 * g + 1), v); chk("R11 events cleared", v, 16'h0);
            rd(4'(3 * g + 2), v); chk("R11 enables kept", v, 16'h7FFF);
        end
        rd(4'd11, v); chk("R11 summaries gone", v, 16'h0);
        for (int g = 0; g < 3; g++) wr(4'(3 * g + 2), 16'h0);

        // R6: standard event pulses
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); std_evt = 8'(1 << i);
            @(negedge clk); std_evt = 8'h0;
            rd(4'd9, v); chk("R6 std event latch", v, 16'((1 << i) & 8'hFD));
            rd(4'd9, v); chk("R6 std read clears", v, 16'h0);
        end
        @(negedge clk); std_evt = 8'h86;
        @(negedge clk); std_evt = 8'h0;
        for (int e = 0; e < 256; e++) begin
            wr(4'd10, 16'(e));
            rd(4'd10, v); chk("R6 std enable bit1 dropped", v, 16'(e & 8'hFD));
            rd(4'd11, v); chk("R6 std summary bit5", v, ((e & 8'h84) != 0) ? 16'h0020 : 16'h0);
        end
        wr(4'd10, 16'h0);
        wr(4'd14, 16'h0);
        rd(4'd9, v); chk("R11 std event cleared", v, 16'h0);

        // R7: queue flags
        msg_avail = 1'b1; rd(4'd11, v); chk("R7 message flag bit4", v, 16'h0010);
        err_avail = 1'b1; rd(4'd11, v); chk("R7 error flag bit2", v, 16'h0014);
        msg_avail = 1'b0; rd(4'd11, v); chk("R7 message flag off", v, 16'h0004);
        msg_avail = 1'b1;

        // R9: service-request enable sweep against status byte 0x14
        for (int s = 0; s < 256; s++) begin
            wr(4'd13, 16'(s));
            rd(4'd13, v); chk("R9 enable bit6 dropped", v, 16'(s & 8'hBF));
            rd(4'd11, v); chk("R9 master summary", v, ((s & 8'h14) != 0) ? 16'h0054 : 16'h0014);
        end
        wr(4'd13, 16'h0);
        rd(4'd12, v);
        rd(4'd12, v); chk("R10 poll without request", v, 16'h0014);
        chk("R10 no flag", {15'b0, srq_out}, 16'h0);

        // R10: request sequence
        err_avail = 1'b0;
        wr(4'd13, 16'h0010);
        @(negedge clk);
        chk("R10 flag set", {15'b0, srq_out}, 16'h1);
        rd(4'd11, v); chk("R9 query shows summary", v, 16'h0050);
        rd(4'd12, v); chk("R10 poll returns flag", v, 16'h0050);
        chk("R10 poll clears", {15'b0, srq_out}, 16'h0);
        rd(4'd12, v); chk("R10 second poll", v, 16'h0010);
        repeat (3) @(negedge clk);
        chk("R10 no refire while high", {15'b0, srq_out}, 16'h0);
        msg_avail = 1'b0; @(negedge clk);
        msg_avail = 1'b1; @(negedge clk);
        chk("R10 refire after fall", {15'b0, srq_out}, 16'h1);

        // R2: writes to read-only selects change nothing
        oper_cond = 16'h0005; @(negedge clk);
        wr(4'd12, 16'hFFFF); chk("R2 poll write keeps flag", {15'b0, srq_out}, 16'h1);
        wr(4'd11, 16'hFFFF);
        wr(4'd0, 16'h0000);
        wr(4'd1, 16'hFFFF);
        wr(4'd9, 16'hFFFF);
        wr(4'd15, 16'hFFFF);
        rd(4'd0, v); chk("R2 condition unchanged", v, 16'h0005);
        rd(4'd1, v); chk("R2 event unchanged", v, 16'h0005);
        rd(4'd2, v); chk("R2 enable unchanged", v, 16'h0);
        rd(4'd9, v); chk("R2 std event unchanged", v, 16'h0);
        chk("R2 flag still set", {15'b0, srq_out}, 16'h1);
        rd(4'd12, v); chk("R10 poll after writes", v, 16'h0050);
        oper_cond = 16'h0;

        // R12: latency, hold and unused select
        rd(4'd15, v); chk("R12 unused select", v, 16'h0);
        meas_cond = 16'h0033; @(negedge clk);
        rd(4'd3, v); chk("R12 read value", v, 16'h0033);
        meas_cond = 16'h0;
        repeat (3) @(negedge clk);
        chk("R12 hold without read", rd_data, 16'h0033);
        @(negedge clk); reg_sel = 4'd3; rd_en = 1'b1;
        #1 chk("R12 not before edge", rd_data, 16'h0033);
        @(negedge clk); rd_en = 1'b0;
        chk("R12 one cycle later", rd_data, 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule